// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM that holds 16-bit words at 6-bit addresses. It generates chip select, serial clock and serial data-out, and it samples the device's serial data-in. A host issues one command at a time on a small request port. A command is a read, a write, a write-enable or a write-disable, with an address and, for writes, a data word. The block answers with a single-cycle completion pulse. For reads it also returns the word it received.

Every bus level is held for a programmable number of system clocks, so the bus rate follows a run-time setting. A frame opens with a start bit and carries an 8-bit instruction field. For a write, that field is followed by the data word. The block then releases and re-selects the device, and it pulses the clock until the device reports ready. A programmable poll budget ends that wait with an error when the device never reports ready.

Top module: `mw_eeprom_master`

## Requirements
- R1: Each command frame begins with `ee_cs` high and `ee_do` high, followed by one clock pulse. That pulse is the start bit and comes before any instruction bit.
- R2: After the start bit, an 8-bit instruction is shifted out MSB first. `ee_do` changes only while `ee_sk` is low. The instruction is `8'h80 | addr` for read (`cmd_op`=0), `8'h40 | addr` for write (`cmd_op`=1), `8'h30` for write-enable (`cmd_op`=2) and `8'h00` for write-disable (`cmd_op`=3).
- R3: A write sends the 16-bit `cmd_wdata` MSB first on the 16 clock pulses that follow the instruction.
- R4: A read applies 16 clock pulses after the instruction. `ee_di` is sampled at the end of the low interval that follows each falling edge, MSB first. `rd_data` holds the assembled word when `done` pulses.
- R5: After the data bits of a write, `ee_cs` drops for one interval and then rises again. Clock pulses then repeat until `ee_di` is seen high, after which the frame closes and `done` pulses.
- R6: During write polling, if `ee_di` is still low after `poll_limit` pulses (a value of 0 counts as 1), the frame closes and `error` rises together with `done`. `error` holds until the next command is accepted. A ready seen on the last allowed pulse is not an error.
- R7: Every level on `ee_cs`, `ee_sk` and `ee_do` inside a command is held for `half_period`+1 system clocks. `half_period` must be at least 1.
- R8: A command is taken only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` pulses. `cmd_valid` has no effect while `busy` is high.
- R9: `done` lasts one cycle, and `ee_cs` and `ee_sk` are low when it pulses.
- R10: While reset is held, `busy`, `done`, `error`, `ee_cs`, `ee_sk` and `ee_do` are low.
- R11: `ee_sk` is high only while `ee_cs` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_op | input | 2 | 0 read, 1 write, 2 write-enable, 3 write-disable |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| half_period | input | HP_W | System clocks per bus level, minus one |
| poll_limit | input | POLL_W | Maximum ready-poll pulses after a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last write timed out waiting for ready |
| rd_data | output | DATA_W | Word received by the last read |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the device |
| ee_di | input | 1 | Serial data from the device |

## Verification
Several rules are checked on every cycle: the clock only pulses under select, data stays still while the clock is high, bus levels keep their minimum hold, the completion pulse is one cycle long and ends the busy window, and an error can only appear with completion. Other behaviour can only be shown by a scenario against a bench model of the device. This covers the instruction bytes and data word, the start bit, read assembly, poll counts on either side of the timeout boundary, a request ignored mid-frame, and how a change of hold setting shows up in clock pulse width.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned INSTR_W = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WREN  = 2'd2,
        OP_WRDIS = 2'd3
    } mw_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_LO,
        ST_START_HI,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TAIL,
        ST_RD_HI,
        ST_RD_LO,
        ST_DESEL,
        ST_RESEL,
        ST_POLL_HI,
        ST_POLL_LO,
        ST_FINISH
    } mw_state_e;
endpackage

// File: rtl/mw_tick.sv
// Interval timer: one tick after limit+1 clocks of run, then restarts.
module mw_tick #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_poll_ctr.sv
// Counts ready-poll pulses; last flags that the budget is used up.
module mw_poll_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)     cnt_d = '0;
        else if (step) cnt_d = cnt_q + W'(1);
        else           cnt_d = cnt_q;
        last = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned HP_W   = 16,
    parameter int unsigned POLL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic [HP_W-1:0]       half_period,
    input  logic [POLL_W-1:0]     poll_limit,
    output logic                  busy,
    output logic                  done,
    output logic                  error,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  ee_cs,
    output logic                  ee_sk,
    output logic                  ee_do,
    input  logic                  ee_di
);
    localparam int unsigned SH_W  = INSTR_W + DATA_W;
    localparam int unsigned BIT_W = $clog2(SH_W + 1);

    typedef struct packed {
        mw_state_e         st;
        mw_op_e            op;
        logic [SH_W-1:0]   sh;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] rd;
        logic              cs;
        logic              sk;
        logic              dout;
        logic              busy;
        logic              done;
        logic              err;
        logic              tmo;
        logic              di_m;
        logic              di_s;
    } regs_t;

    regs_t d, q;

    logic               tick;
    logic               poll_clear;
    logic               poll_step;
    logic               poll_last;
    mw_op_e             op_in;
    logic [INSTR_W-1:0] instr;

    mw_tick #(.W(HP_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.busy),
        .limit (half_period),
        .tick  (tick)
    );

    mw_poll_ctr #(.W(POLL_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (poll_step),
        .limit (poll_limit),
        .last  (poll_last)
    );

    // Instruction byte for the requested operation
    always_comb begin
        op_in = mw_op_e'(cmd_op);
        case (op_in)
            OP_READ:  instr = {2'b10, cmd_addr};
            OP_WRITE: instr = {2'b01, cmd_addr};
            OP_WREN:  instr = 8'h30;
            default:  instr = 8'h00;
        endcase
    end

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.di_m     = ee_di;
        d.di_s     = q.di_m;
        poll_clear = 1'b0;
        poll_step  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.op   = op_in;
                    d.sh   = {instr, cmd_wdata};
                    d.bits = (op_in == OP_WRITE) ? BIT_W'(SH_W) : BIT_W'(INSTR_W);
                    d.cs   = 1'b1;
                    d.dout = 1'b1;
                    d.sk   = 1'b0;
                    d.busy = 1'b1;
                    d.err  = 1'b0;
                    d.tmo  = 1'b0;
                    d.st   = ST_START_LO;
                end
            end
            ST_START_LO: if (tick) begin
                d.sk = 1'b1;
                d.st = ST_START_HI;
            end
            ST_START_HI: if (tick) begin
                d.sk   = 1'b0;
                d.dout = q.sh[SH_W-1];
                d.st   = ST_BIT_LO;
            end
            ST_BIT_LO: if (tick) begin
                d.sk = 1'b1;
                d.st = ST_BIT_HI;
            end
            ST_BIT_HI: if (tick) begin
                d.sh   = q.sh << 1;
                d.bits = q.bits - BIT_W'(1);
                d.sk   = 1'b0;
                if (q.bits == BIT_W'(1)) begin
                    d.dout = 1'b0;
                    d.st   = ST_TAIL;
                end else begin
                    d.dout = q.sh[SH_W-2];
                    d.st   = ST_BIT_LO;
                end
            end
            ST_TAIL: if (tick) begin
                case (q.op)
                    OP_READ: begin
                        d.sk   = 1'b1;
                        d.bits = BIT_W'(DATA_W);
                        d.st   = ST_RD_HI;
                    end
                    OP_WRITE: begin
                        d.cs = 1'b0;
                        d.st = ST_DESEL;
                    end
                    default: begin
                        d.cs = 1'b0;
                        d.st = ST_FINISH;
                    end
                endcase
            end
            ST_RD_HI: if (tick) begin
                d.sk = 1'b0;
                d.st = ST_RD_LO;
            end
            ST_RD_LO: if (tick) begin
                d.rd   = {q.rd[DATA_W-2:0], q.di_s};
                d.bits = q.bits - BIT_W'(1);
                if (q.bits == BIT_W'(1)) begin
                    d.cs = 1'b0;
                    d.st = ST_FINISH;
                end else begin
                    d.sk = 1'b1;
                    d.st = ST_RD_HI;
                end
            end
            ST_DESEL: if (tick) begin
                d.cs       = 1'b1;
                poll_clear = 1'b1;
                d.st       = ST_RESEL;
            end
            ST_RESEL: if (tick) begin
                d.sk = 1'b1;
                d.st = ST_POLL_HI;
            end
            ST_POLL_HI: if (tick) begin
                d.sk = 1'b0;
                d.st = ST_POLL_LO;
            end
            ST_POLL_LO: if (tick) begin
                if (q.di_s) begin
                    d.cs = 1'b0;
                    d.st = ST_FINISH;
                end else if (poll_last) begin
                    d.tmo = 1'b1;
                    d.cs  = 1'b0;
                    d.st  = ST_FINISH;
                end else begin
                    poll_step = 1'b1;
                    d.sk      = 1'b1;
                    d.st      = ST_POLL_HI;
                end
            end
            ST_FINISH: if (tick) begin
                d.done = 1'b1;
                d.err  = q.tmo;
                d.busy = 1'b0;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign error   = q.err;
    assign rd_data = q.rd;
    assign ee_cs   = q.cs;
    assign ee_sk   = q.sk;
    assign ee_do   = q.dout;
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk #(
    parameter int unsigned HP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            busy,
    input logic            done,
    input logic            error,
    input logic            ee_cs,
    input logic            ee_sk,
    input logic            ee_do,
    input logic [HP_W-1:0] half_period
);
    logic [2:0]    bus_q;
    logic [HP_W:0] gap_q;
    logic          change;

    assign change = ({ee_cs, ee_sk, ee_do} != bus_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            gap_q <= '0;
        end else begin
            bus_q <= {ee_cs, ee_sk, ee_do};
            if (change)          gap_q <= '0;
            else if (gap_q != '1) gap_q <= gap_q + (HP_W+1)'(1);
        end
    end

    p_sk_needs_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    p_do_still_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_do));

    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (change && $past(busy)) |-> (gap_q >= {1'b0, half_period}));

    p_take_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_bus_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ee_cs && !ee_sk));

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
endmodule

bind mw_eeprom_master mw_master_chk #(.HP_W(HP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .ee_cs       (ee_cs),
    .ee_sk       (ee_sk),
    .ee_do       (ee_do),
    .half_period (half_period)
);

// File: tb/mw_eeprom_master_tb_top.sv
module mw_eeprom_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] half_period = 16'd3;
    logic [15:0] poll_limit = 16'd8;
    logic        busy, done, error, ee_cs, ee_sk, ee_do, ee_di;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    mw_eeprom_master dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .half_period(half_period),
        .poll_limit(poll_limit), .busy(busy), .done(done), .error(error),
        .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [15:0] mem [64];
    logic        wen_m = 1'b0;
    logic        di_m = 1'b0;
    logic        start_m = 1'b0;
    logic [7:0]  instr_m = '0;
    logic [15:0] wsh = '0;
    int          rises = 0;
    int          frames = 0;
    bit          poll_mode = 1'b0;
    bit          pend = 1'b0;
    int          busy_left = 0;
    int          busy_polls = 2;
    int          poll_pulses = 0;

    assign ee_di = di_m;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'h5A00 | 16'(i);

    always @(posedge ee_cs) begin
        if (pend) begin
            poll_mode = 1'b1;
            di_m = (busy_left == 0);
        end else begin
            rises = 0;
            frames++;
            poll_mode = 1'b0;
        end
    end

    always @(negedge ee_cs) begin
        if (poll_mode) begin
            poll_mode = 1'b0;
            pend = 1'b0;
        end else if (rises == 9 && instr_m[7:6] == 2'b00) begin
            if (instr_m[5:4] == 2'b11) wen_m = 1'b1;
            else if (instr_m[5:4] == 2'b00) wen_m = 1'b0;
        end else if (rises == 25 && instr_m[7:6] == 2'b01) begin
            if (wen_m) mem[instr_m[5:0]] = wsh;
            busy_left = wen_m ? busy_polls : 0;
            pend = 1'b1;
        end
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            if (poll_mode) begin
                poll_pulses++;
                if (busy_left > 0) busy_left--;
                di_m = (busy_left == 0);
            end else begin
                rises++;
                if (rises == 1) start_m = ee_do;
                else if (rises <= 9) instr_m = {instr_m[6:0], ee_do};
                else if (instr_m[7:6] == 2'b01 && rises <= 25) wsh = {wsh[14:0], ee_do};
                else if (instr_m[7:6] == 2'b10 && rises <= 25) di_m = mem[instr_m[5:0]][25-rises];
            end
        end
    end

    // sk-high width in system clocks
    int hi_run = 0;
    int last_hi = 0;
    always @(negedge clk) begin
        if (ee_sk) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    function automatic logic [7:0] exp_instr(input logic [1:0] op, input logic [5:0] a);
        case (op)
            2'd0:    return {2'b10, a};
            2'd1:    return {2'b01, a};
            2'd2:    return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd,
                           output logic [15:0] r, output logic e, output logic b,
                           output logic ok);
        int n;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        b = busy;
        n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        ok = done;
        r = rd_data;
        e = error;
    endtask

    // {op, addr, wdata, expected read word}
    localparam logic [39:0] VEC [12] = '{
        {2'd2, 6'd0,  16'h0000, 16'h0000},
        {2'd1, 6'd5,  16'h1234, 16'h0000},
        {2'd0, 6'd5,  16'h0000, 16'h1234},
        {2'd1, 6'd63, 16'hBEEF, 16'h0000},
        {2'd0, 6'd63, 16'h0000, 16'hBEEF},
        {2'd0, 6'd7,  16'h0000, 16'h5A07},
        {2'd3, 6'd0,  16'h0000, 16'h0000},
        {2'd1, 6'd5,  16'hFFFF, 16'h0000},
        {2'd0, 6'd5,  16'h0000, 16'h1234},
        {2'd2, 6'd0,  16'h0000, 16'h0000},
        {2'd1, 6'd0,  16'h8001, 16'h0000},
        {2'd0, 6'd0,  16'h0000, 16'h8001}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        logic e, b, ok;
        bit exp_en;
        int f0;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk({busy, done, error, ee_cs, ee_sk, ee_do} == 6'b0, "R10", "outputs in reset",
            {busy, done, error, ee_cs, ee_sk, ee_do}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        exp_en = 1'b0;
        foreach (VEC[i]) begin
            logic [1:0]  op;
            logic [5:0]  a;
            logic [15:0] wd, er;
            {op, a, wd, er} = VEC[i];
            poll_pulses = 0;
            run_cmd(op, a, wd, r, e, b, ok);
            chk(ok === 1'b1, "R9", "done seen", ok, 1);
            chk(b === 1'b1, "R8", "busy after accept", b, 1);
            chk(start_m === 1'b1, "R1", "start bit", start_m, 1);
            chk(instr_m == exp_instr(op, a), "R2", "instruction byte", instr_m, exp_instr(op, a));
            chk(e === 1'b0, "R6", "no error", e, 0);
            if (op == 2'd2) exp_en = 1'b1;
            if (op == 2'd3) exp_en = 1'b0;
            if (op == 2'd0) chk(r == er, "R4", "read word", r, er);
            if (op == 2'd1) begin
                chk(wsh == wd, "R3", "write data shifted", wsh, wd);
                chk(poll_pulses == (exp_en ? 2 : 1), "R5", "poll pulses", poll_pulses, exp_en ? 2 : 1);
            end
            @(negedge clk);
            chk(!done && !ee_cs && !ee_sk, "R9", "done one cycle, bus low",
                {done, ee_cs, ee_sk}, 0);
        end

        // R7: hold per level follows half_period
        chk(last_hi == 4, "R7", "sk high clocks at half_period 3", last_hi, 4);
        half_period = 16'd5;
        run_cmd(2'd0, 6'd5, 16'h0, r, e, b, ok);
        chk(last_hi == 6, "R7", "sk high clocks at half_period 5", last_hi, 6);
        chk(r == 16'h1234, "R4", "read at slower rate", r, 16'h1234);
        half_period = 16'd3;

        // R6: timeout boundary
        poll_limit = 16'd5;
        run_cmd(2'd2, 6'd0, 16'h0, r, e, b, ok);
        busy_polls = 5;
        poll_pulses = 0;
        run_cmd(2'd1, 6'd9, 16'hA55A, r, e, b, ok);
        chk(e === 1'b0, "R6", "ready on last allowed pulse", e, 0);
        chk(poll_pulses == 5, "R5", "pulses until ready", poll_pulses, 5);
        busy_polls = 6;
        poll_pulses = 0;
        run_cmd(2'd1, 6'd9, 16'h5AA5, r, e, b, ok);
        chk(e === 1'b1, "R6", "timeout flagged", e, 1);
        chk(poll_pulses == 5, "R6", "pulses before timeout", poll_pulses, 5);
        repeat (10) @(negedge clk);
        chk(error === 1'b1, "R6", "error held while idle", error, 1);
        busy_polls = 2;
        run_cmd(2'd3, 6'd0, 16'h0, r, e, b, ok);
        chk(e === 1'b0, "R6", "error cleared by next command", e, 0);

        // R8: request while busy is ignored
        f0 = frames;
        @(negedge clk);
        cmd_op = 2'd0; cmd_addr = 6'd63; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        cmd_op = 2'd1; cmd_addr = 6'd9; cmd_wdata = 16'h0000; cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int n = 0;
            while (!done && n < 30000) begin
                @(negedge clk);
                n++;
            end
        end
        chk(rd_data == 16'hBEEF, "R8", "read undisturbed", rd_data, 16'hBEEF);
        chk(instr_m == 8'hBF, "R8", "instruction of accepted command", instr_m, 8'hBF);
        repeat (50) @(negedge clk);
        chk(frames == f0 + 1, "R8", "frames started", frames, f0 + 1);
        chk(busy === 1'b0, "R8", "idle after ignored request", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule